// File: doc/BRIEF.md
# Thermal Activity Throttle Controller

This controller watches a stream of digitized junction-temperature readings from an on-chip diode sensor. When the silicon runs too hot, it cuts the activity of the logic it protects. Each reading comes with a valid strobe. The controller compares the reading against a programmable trip level and a lower release level. The gap between the two levels gives hysteresis, so the controller does not chatter around the limit.

While throttled, the controller reduces activity in one of two ways, chosen by a mode input:

- **Gating mode.** A clock-enable output is held high for only M cycles out of every eight. This duty cycle sets the average switching activity of the protected logic.
- **Divide mode.** A divide-select code steps the clock ratio up or down one notch per reading, between 1 and 8. The code drives an external divider.

A sticky over-temperature flag records every trip until a clear strobe arrives. The analog sensor, the clock divider and the gating cell sit outside this block.

Top module: `thermal_throttle`

## Requirements
- R1: After reset the block is unthrottled: `clk_en` is 1, `div_sel` is 0, `throttled` is 0 and `over_flag` is 0.
- R2: A valid reading strictly greater than `trip_level` sets `throttled` on the next clock edge. A reading equal to or below `trip_level` does not set it.
- R3: While `temp_valid` is 0, `temp_code` has no effect on `throttled`, `div_sel` or `over_flag`.
- R4: Once throttled in gating mode, the block stays throttled for readings from `release_level` up to `trip_level` inclusive. It leaves throttling on the edge after a valid reading strictly below `release_level`.
- R5: In gating mode (`mode_div`=0) while throttled, `clk_en` is high in exactly M of any 8 consecutive cycles. M is `duty_m` (3 bits), and the value 0 counts as M=1. While unthrottled, `clk_en` is held at 1.
- R6: In divide mode (`mode_div`=1), `div_sel` encodes the ratio as 0=÷1, 1=÷2, 2=÷4 and 3=÷8. Each over-trip reading raises `div_sel` by one step, saturating at 3. `clk_en` stays at 1 in this mode.
- R7: In divide mode, each reading below `release_level` lowers `div_sel` by one step, stopping at 0. `throttled` clears on the step that brings `div_sel` to 0.
- R8: `over_flag` is set by every over-trip reading and holds until `flag_clr` is pulsed. If a new trip and `flag_clr` arrive in the same cycle, the flag stays set.
- R9: In gating mode `div_sel` is 0 after every clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| temp_code | input | 8 | Junction temperature in °C, unsigned |
| temp_valid | input | 1 | Strobe marking `temp_code` as a new reading |
| trip_level | input | 8 | Throttling engages above this temperature (typically 125) |
| release_level | input | 8 | Throttling releases below this temperature |
| mode_div | input | 1 | 0 = duty-cycle gating, 1 = frequency division |
| duty_m | input | 3 | Enabled cycles per 8 in gating mode (0 counts as 1) |
| flag_clr | input | 1 | Write-one-to-clear strobe for `over_flag` |
| clk_en | output | 1 | Clock enable for the protected logic |
| div_sel | output | 2 | Divide ratio code (0..3 meaning 1, 2, 4, 8) |
| throttled | output | 1 | Throttled state |
| over_flag | output | 1 | Sticky over-temperature record |

## Verification
The bench sweeps every reading value against a fixed trip level. A comparator that used greater-or-equal would trip at exactly the limit, and an off-by-one would show up at either neighbour.

A second sweep walks readings through the hysteresis band. A design that released at or above the release level, or that ignored hysteresis, would drop out of throttling too early.

Every duty value from 0 to 7 is counted over an eight-cycle window, which catches a wrong zero-clamp or a window that ends one phase late. The divide sequence is driven past both saturation ends, the flag is cleared in the same cycle as a new trip, and unstrobed hot readings are applied to show they are ignored.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int TEMP_W  = 8;
  localparam int PHASE_W = 3;
  localparam int LVL_W   = 2;

  typedef enum logic [LVL_W-1:0] {
    RATIO_1 = 2'd0,
    RATIO_2 = 2'd1,
    RATIO_4 = 2'd2,
    RATIO_8 = 2'd3
  } ratio_e;
endpackage

// File: rtl/thr_classify.sv
module thr_classify #(
  parameter int TEMP_W = 8
) (
  input  logic [TEMP_W-1:0] temp_code,
  input  logic              temp_valid,
  input  logic [TEMP_W-1:0] trip_level,
  input  logic [TEMP_W-1:0] release_level,
  output logic              hot,
  output logic              cool
);
  // A reading counts only on its strobe; trip wins over release if misprogrammed.
  always_comb begin
    hot  = temp_valid && (temp_code > trip_level);
    cool = temp_valid && (temp_code < release_level) && !hot;
  end
endmodule

// File: rtl/thr_state.sv
module thr_state #(
  parameter int LVL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hot,
  input  logic             cool,
  input  logic             mode_div,
  input  logic             flag_clr,
  output logic             throttled,
  output logic [LVL_W-1:0] lvl,
  output logic             over_flag
);
  localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};
  localparam logic [LVL_W-1:0] LVL_ONE = LVL_W'(1);

  logic             thr_q, thr_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             flg_q, flg_d;

  always_comb begin
    thr_d = thr_q;
    lvl_d = lvl_q;
    if (!mode_div) lvl_d = '0;
    if (hot) begin
      thr_d = 1'b1;
      if (mode_div && lvl_q != LVL_MAX) lvl_d = lvl_q + LVL_ONE;
    end else if (cool) begin
      if (!mode_div || lvl_q <= LVL_ONE) thr_d = 1'b0;
      if (mode_div && lvl_q != '0) lvl_d = lvl_q - LVL_ONE;
    end
  end

  always_comb begin
    flg_d = flg_q;
    if (flag_clr) flg_d = 1'b0;
    if (hot)      flg_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= 1'b0;
      lvl_q <= '0;
      flg_q <= 1'b0;
    end else begin
      thr_q <= thr_d;
      lvl_q <= lvl_d;
      flg_q <= flg_d;
    end
  end

  assign throttled = thr_q;
  assign lvl       = lvl_q;
  assign over_flag = flg_q;

  // R3: no reading, no state change
  a_r3_hold_without_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (!hot && !cool && mode_div) |=> ($stable(thr_q) && $stable(lvl_q)));

  // R6: divide code moves at most one step per edge while in divide mode
  a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_div && $past(mode_div)) |-> (lvl_q == $past(lvl_q) ||
      lvl_q == LVL_W'($past(lvl_q) + LVL_ONE) || LVL_W'(lvl_q + LVL_ONE) == $past(lvl_q)));

  // R8: flag is sticky until cleared
  a_r8_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_q && !flag_clr) |=> flg_q);

  // R9: gating mode leaves the divide code at ratio 1
  a_r9_gate_no_div: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_div |=> (lvl_q == '0));
endmodule

// File: rtl/thr_gate.sv
module thr_gate #(
  parameter int PHASE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               throttled,
  input  logic               mode_div,
  input  logic [PHASE_W-1:0] duty_m,
  output logic               clk_en
);
  logic [PHASE_W-1:0] phase_q, phase_d;
  logic [PHASE_W-1:0] m_eff;

  always_comb begin
    phase_d = phase_q + PHASE_W'(1);
    m_eff   = (duty_m == '0) ? PHASE_W'(1) : duty_m;
    clk_en  = !throttled || mode_div || (phase_q < m_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  // R5: unthrottled logic runs every cycle
  a_r5_idle_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !throttled |-> clk_en);

  // R6: divide mode never gates
  a_r6_div_enable: assert property (@(posedge clk) disable iff (!rst_n)
    mode_div |-> clk_en);

  // R5: each gated window opens at phase zero
  a_r5_window_open: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == '0) |-> clk_en);
endmodule

// File: rtl/thermal_throttle.sv
module thermal_throttle
  import thr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic              temp_valid,
  input  logic [TEMP_W-1:0] trip_level,
  input  logic [TEMP_W-1:0] release_level,
  input  logic              mode_div,
  input  logic [PHASE_W-1:0] duty_m,
  input  logic              flag_clr,
  output logic              clk_en,
  output logic [LVL_W-1:0]  div_sel,
  output logic              throttled,
  output logic              over_flag
);
  logic [1:0] rst_pipe_q;
  logic       rst_n_int;
  logic       hot, cool;
  logic [LVL_W-1:0] lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  thr_classify #(.TEMP_W(TEMP_W)) u_classify (
    .temp_code(temp_code), .temp_valid(temp_valid),
    .trip_level(trip_level), .release_level(release_level),
    .hot(hot), .cool(cool)
  );

  thr_state #(.LVL_W(LVL_W)) u_state (
    .clk(clk), .rst_n(rst_n_int), .hot(hot), .cool(cool),
    .mode_div(mode_div), .flag_clr(flag_clr),
    .throttled(throttled), .lvl(lvl), .over_flag(over_flag)
  );

  thr_gate #(.PHASE_W(PHASE_W)) u_gate (
    .clk(clk), .rst_n(rst_n_int), .throttled(throttled),
    .mode_div(mode_div), .duty_m(duty_m), .clk_en(clk_en)
  );

  assign div_sel = lvl;

  // R1: held reset forces the idle outputs
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n_int |-> (clk_en && div_sel == '0 && !throttled));
endmodule

// File: tb/thermal_throttle_tb.sv
module thermal_throttle_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TRIP = 125;
  localparam int REL  = 100;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] temp_code;
  logic       temp_valid;
  logic [7:0] trip_level, release_level;
  logic       mode_div;
  logic [2:0] duty_m;
  logic       flag_clr;
  logic       clk_en;
  logic [1:0] div_sel;
  logic       throttled, over_flag;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_throttle u_dut (
    .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .temp_valid(temp_valid),
    .trip_level(trip_level), .release_level(release_level), .mode_div(mode_div),
    .duty_m(duty_m), .flag_clr(flag_clr), .clk_en(clk_en), .div_sel(div_sel),
    .throttled(throttled), .over_flag(over_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic sample(input int t);
    @(negedge clk);
    temp_code  = 8'(t);
    temp_valid = 1'b1;
    @(negedge clk);
    temp_valid = 1'b0;
  endtask

  task automatic count_en(output int c);
    c = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (clk_en) c++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int c;
    rst_n = 1'b0; temp_code = '0; temp_valid = 1'b0;
    trip_level = 8'(TRIP); release_level = 8'(REL);
    mode_div = 1'b0; duty_m = 3'd3; flag_clr = 1'b0;
    do_reset();

    // R1 reset state
    chk("R1 clk_en", int'(clk_en), 1);
    chk("R1 div_sel", int'(div_sel), 0);
    chk("R1 throttled", int'(throttled), 0);
    chk("R1 over_flag", int'(over_flag), 0);

    // R3 unstrobed hot readings are ignored
    @(negedge clk);
    temp_code = 8'd255;
    repeat (5) @(negedge clk);
    chk("R3 throttled", int'(throttled), 0);
    chk("R3 over_flag", int'(over_flag), 0);
    chk("R3 div_sel", int'(div_sel), 0);

    // R2 sweep every reading against the trip level, gating mode
    for (int t = 0; t < 256; t++) begin
      sample(t);
      chk("R2 trip sweep", int'(throttled), (t > TRIP) ? 1 : 0);
      chk("R9 gate div", int'(div_sel), 0);
      if (throttled) sample(0);
    end

    // R4 hysteresis band sweep
    for (int t = REL - 10; t <= TRIP; t++) begin
      sample(TRIP + 1);
      sample(t);
      chk("R4 hysteresis", int'(throttled), (t < REL) ? 0 : 1);
      if (throttled) sample(0);
    end

    // R5 duty sweep while throttled
    sample(200);
    for (int m = 0; m < 8; m++) begin
      @(negedge clk);
      duty_m = 3'(m);
      count_en(c);
      chk("R5 duty count", c, (m == 0) ? 1 : m);
    end
    sample(0);
    count_en(c);
    chk("R5 idle enable", c, 8);

    // R8 sticky flag and clear
    chk("R8 flag held", int'(over_flag), 1);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    chk("R8 flag cleared", int'(over_flag), 0);
    @(negedge clk);
    temp_code = 8'd200; temp_valid = 1'b1; flag_clr = 1'b1;
    @(negedge clk);
    temp_valid = 1'b0; flag_clr = 1'b0;
    chk("R8 set wins over clear", int'(over_flag), 1);
    sample(0);

    // R6 / R7 divide mode stepping
    do_reset();
    mode_div = 1'b1;
    for (int s = 1; s <= 5; s++) begin
      sample(TRIP + s);
      chk("R6 step up", int'(div_sel), (s > 3) ? 3 : s);
      chk("R6 throttled", int'(throttled), 1);
      chk("R6 clk_en high", int'(clk_en), 1);
    end
    sample(110);
    chk("R7 band hold", int'(div_sel), 3);
    for (int s = 1; s <= 4; s++) begin
      sample(REL - s);
      chk("R7 step down", int'(div_sel), (s > 3) ? 0 : 3 - s);
      chk("R7 throttled", int'(throttled), (s >= 3) ? 0 : 1);
    end

    // R9 returning to gating mode clears the ratio
    sample(TRIP + 1);
    sample(TRIP + 1);
    @(negedge clk); mode_div = 1'b0;
    @(negedge clk);
    chk("R9 gate clears div", int'(div_sel), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule